// File: doc/BRIEF.md
# Bit-Serial Configuration Register Port

This block holds a 64-bit configuration word that a host reaches through a narrow synchronous register bus, one bit per access. A six-bit bit index selects the bit that the next access touches. Each write to the data offset stores bit 0 of the write data into the indexed bit, and each strobed read of the data offset returns the indexed bit. Both kinds of access then step the index forward. A write to a separate rewind offset returns the index to bit 0 and leaves the stored bits alone.

The host loads the whole word by rewinding once and then issuing 64 single-bit writes, lowest bit first. It reads the word back the same way. The complete word is driven at all times on a parallel output, so that memory-timing logic can use the settings without going through the bus.

Top module: `cfgser_port`

## Requirements
- R1: After a synchronous reset, `cfg_word` is all zeros, the bit index is 0 and `rd_data` is zero.
- R2: A write (`sel`=1, `wr_en`=1) to offset 0 sets the indexed bit of `cfg_word` when `wr_data[0]` is 1 and clears it when `wr_data[0]` is 0. Bits 31:1 of `wr_data` have no effect. The change shows on `cfg_word` after that clock edge.
- R3: Each write to offset 0 steps the bit index up by one after the bit has been stored. The index goes from 63 back to 0.
- R4: A strobed read (`sel`=1, `rd_stb`=1) of offset 0 places the indexed bit in `rd_data[0]`, with `rd_data[31:1]` zero, in the cycle after the strobe. The read also steps the index up by one, going from 63 back to 0.
- R5: A write to offset 8 sets the bit index to 0 and leaves `cfg_word` unchanged.
- R6: A strobed read of any offset other than 0 gives `rd_data` = 0 in the next cycle and leaves the index unchanged.
- R7: The following accesses change neither `cfg_word` nor the index: writes to any offset other than 0 or 8, and any cycle with `sel` low.
- R8: A write to offset 8 combined with a read strobe in the same cycle leaves the index at 0, because the rewind takes priority over any step. `rd_data` is zero in the next cycle.
- R9: A write and a read strobe together at offset 0 step the index by one only. `rd_data[0]` returns the bit value from before the write, and the written value is stored.
- R10: `rd_data` keeps its value in every cycle that has no strobed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Block select for this cycle's access |
| wr_en | input | 1 | Write request |
| rd_stb | input | 1 | One-cycle read strobe |
| offset | input | 16 | Byte offset within the block window |
| wr_data | input | 32 | Write data; only bit 0 is used |
| rd_data | output | 32 | Registered read data, valid the cycle after `rd_stb` |
| cfg_word | output | 64 | Full configuration word, driven continuously |

## Verification
A wrong bit index is not visible at once. It shows only through later accesses: the next data write lands on the wrong bit of `cfg_word` one edge later, and the next strobed read returns the wrong bit in the following cycle. For this reason the bench compares both outputs after every access against a model, so that an index slip is caught at the first access that follows it. A corrupt storage bit shows on `cfg_word` at once. A wrong readback shows one cycle after the strobe. Wrap from 63 to 0, rewind priority and ignored offsets are driven directly, and the bench then observes the effect through the next write or read.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;

    // Decoded bus access for one cycle
    typedef struct packed {
        logic bit_wr;   // write to the data offset
        logic bit_rd;   // strobed read of the data offset
        logic rewind;   // write to the rewind offset
        logic any_rd;   // strobed read of any offset
    } acc_t;

    // Next bit index with wrap at the last bit
    function automatic int unsigned next_index(input int unsigned cur,
                                               input int unsigned nbits);
        return (cur == nbits - 1) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/cfgser_decode.sv
module cfgser_decode
    import cfgser_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned OFS_DATA   = 0,
    parameter int unsigned OFS_REWIND = 8
) (
    input  logic              sel,
    input  logic              wr_en,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] offset,
    output acc_t              acc
);
    localparam logic [ADDR_W-1:0] DATA_A   = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] REWIND_A = ADDR_W'(OFS_REWIND);

    logic hit_data, hit_rew;

    always_comb begin
        hit_data   = (offset == DATA_A);
        hit_rew    = (offset == REWIND_A);
        acc.bit_wr = sel & wr_en  & hit_data;
        acc.rewind = sel & wr_en  & hit_rew;
        acc.bit_rd = sel & rd_stb & hit_data;
        acc.any_rd = sel & rd_stb;
    end
endmodule

// File: rtl/cfgser_ptr.sv
module cfgser_ptr
    import cfgser_pkg::*;
#(
    parameter int unsigned CFG_BITS = 64,
    localparam int unsigned PTR_W   = $clog2(CFG_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             rewind,
    output logic [PTR_W-1:0] ptr
);
    logic [PTR_W-1:0] ptr_nxt;

    always_comb begin
        if (rewind)
            ptr_nxt = '0;
        else if (advance)
            ptr_nxt = PTR_W'(next_index(int'(ptr), CFG_BITS));
        else
            ptr_nxt = ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) ptr <= '0;
        else     ptr <= ptr_nxt;
    end

    // R5 R8
    rewind_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rewind |=> (ptr == '0));

    // R3
    step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !rewind && ptr == PTR_W'(CFG_BITS-1)) |=> (ptr == '0));

    // R3 R4 R9
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !rewind && ptr != PTR_W'(CFG_BITS-1)) |=> (ptr == $past(ptr) + 1'b1));

    // R6 R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!advance && !rewind) |=> $stable(ptr));
endmodule

// File: rtl/cfgser_store.sv
module cfgser_store #(
    parameter int unsigned CFG_BITS = 64,
    localparam int unsigned PTR_W   = $clog2(CFG_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [PTR_W-1:0]    idx,
    input  logic                val,
    output logic [CFG_BITS-1:0] cfg
);
    for (genvar i = 0; i < CFG_BITS; i++) begin : g_bit
        logic hit;
        assign hit = we && (idx == PTR_W'(i));
        always_ff @(posedge clk) begin
            if (rst)      cfg[i] <= 1'b0;
            else if (hit) cfg[i] <= val;
        end
    end

    // R2
    bit_store_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (cfg[$past(idx)] == $past(val)));

    // R5 R7
    no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(cfg));
endmodule

// File: rtl/cfgser_rdback.sv
module cfgser_rdback #(
    parameter int unsigned CFG_BITS = 64,
    parameter int unsigned DATA_W   = 32,
    localparam int unsigned PTR_W   = $clog2(CFG_BITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                any_rd,
    input  logic                bit_rd,
    input  logic [CFG_BITS-1:0] cfg,
    input  logic [PTR_W-1:0]    idx,
    output logic [DATA_W-1:0]   rdata
);
    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (any_rd)
            rdata <= bit_rd ? {{(DATA_W-1){1'b0}}, cfg[idx]} : '0;
    end

    // R4
    bit_read_chk: assert property (@(posedge clk) disable iff (rst)
        bit_rd |=> (rdata == {{(DATA_W-1){1'b0}}, $past(cfg[idx])}));

    // R6
    other_read_chk: assert property (@(posedge clk) disable iff (rst)
        (any_rd && !bit_rd) |=> (rdata == '0));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !any_rd |=> $stable(rdata));
endmodule

// File: rtl/cfgser_port.sv
module cfgser_port
    import cfgser_pkg::*;
#(
    parameter int unsigned CFG_BITS   = 64,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned OFS_DATA   = 0,
    parameter int unsigned OFS_REWIND = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel,
    input  logic                wr_en,
    input  logic                rd_stb,
    input  logic [ADDR_W-1:0]   offset,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    output logic [CFG_BITS-1:0] cfg_word
);
    localparam int unsigned PTR_W = $clog2(CFG_BITS);

    acc_t             acc;
    logic [PTR_W-1:0] bit_idx;

    cfgser_decode #(
        .ADDR_W    (ADDR_W),
        .OFS_DATA  (OFS_DATA),
        .OFS_REWIND(OFS_REWIND)
    ) u_decode (
        .sel   (sel),
        .wr_en (wr_en),
        .rd_stb(rd_stb),
        .offset(offset),
        .acc   (acc)
    );

    cfgser_ptr #(.CFG_BITS(CFG_BITS)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .advance(acc.bit_wr | acc.bit_rd),
        .rewind (acc.rewind),
        .ptr    (bit_idx)
    );

    cfgser_store #(.CFG_BITS(CFG_BITS)) u_store (
        .clk(clk),
        .rst(rst),
        .we (acc.bit_wr),
        .idx(bit_idx),
        .val(wr_data[0]),
        .cfg(cfg_word)
    );

    cfgser_rdback #(.CFG_BITS(CFG_BITS), .DATA_W(DATA_W)) u_rdback (
        .clk   (clk),
        .rst   (rst),
        .any_rd(acc.any_rd),
        .bit_rd(acc.bit_rd),
        .cfg   (cfg_word),
        .idx   (bit_idx),
        .rdata (rd_data)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (cfg_word == '0 && rd_data == '0));
endmodule

// File: tb/sim_cfgser_port.sv
module sim_cfgser_port;
    logic        clk = 1'b0;
    logic        rst;
    logic        sel, wr_en, rd_stb;
    logic [15:0] offset;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [63:0] cfg_word;

    int unsigned errors = 0;
    int unsigned checks = 0;

    logic [63:0] m_cfg;
    int unsigned m_ptr;
    logic [31:0] m_rdata;

    always #5 clk = ~clk;

    cfgser_port u0 (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .rd_stb(rd_stb),
        .offset(offset), .wr_data(wr_data), .rd_data(rd_data), .cfg_word(cfg_word)
    );

    function automatic int unsigned step(input int unsigned p);
        return (p == 63) ? 0 : p + 1;
    endfunction

    task automatic check(input string tag);
        checks++;
        if (rd_data !== m_rdata) begin
            errors++;
            $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, m_rdata);
        end
        checks++;
        if (cfg_word !== m_cfg) begin
            errors++;
            $display("FAIL %s cfg_word actual=%h expected=%h", tag, cfg_word, m_cfg);
        end
    endtask

    // Drive one access at a negedge, model it, check at the next negedge.
    task automatic access(input logic s, input logic w, input logic r,
                          input logic [15:0] o, input logic [31:0] d,
                          input string tag);
        int unsigned p;
        sel = s; wr_en = w; rd_stb = r; offset = o; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        p = m_ptr;
        if (s && r) m_rdata = (o == 16'd0) ? {31'b0, m_cfg[p]} : 32'b0;
        if (s && w && o == 16'd0) m_cfg[p] = d[0];
        if (s && w && o == 16'd8) m_ptr = 0;
        else if (s && o == 16'd0 && (w || r)) m_ptr = step(p);
        sel = 0; wr_en = 0; rd_stb = 0; offset = '0; wr_data = '0;
        check(tag);
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [63:0] pat;
        void'($urandom(32'h5eed_0042));
        sel = 0; wr_en = 0; rd_stb = 0; offset = '0; wr_data = '0;
        rst = 1;
        m_cfg = '0; m_ptr = 0; m_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 reset");

        // R2 R3: load a pattern, upper wr_data bits carry noise
        pat = 64'hA5C3_0F1E_9B27_6D48;
        for (int i = 0; i < 64; i++)
            access(1, 1, 0, 16'd0, {~{31{pat[i]}}, pat[i]}, "R2 load");
        // R3 wrap: 65th write lands on bit 0
        access(1, 1, 0, 16'd0, 32'd0, "R3 wrap write");
        // R5 rewind, contents unchanged
        access(1, 1, 0, 16'd8, 32'hFFFF_FFFF, "R5 rewind");
        // R4 read back all bits and one wrap read
        for (int i = 0; i < 65; i++)
            access(1, 0, 1, 16'd0, 32'd0, "R4 readback");
        // R6 read other offsets: zero, pointer held
        access(1, 0, 1, 16'd8, 32'd0, "R6 read off8");
        access(1, 0, 1, 16'd4, 32'd0, "R6 read off4");
        access(1, 0, 1, 16'd0, 32'd0, "R6 pointer held");
        // R7 ignored writes and deselected cycles
        access(1, 1, 0, 16'd4, 32'd1, "R7 write off4");
        access(1, 1, 0, 16'h0100, 32'd1, "R7 write far");
        access(0, 1, 1, 16'd0, 32'd1, "R7 sel low");
        access(0, 1, 0, 16'd8, 32'd0, "R7 sel low rewind");
        access(1, 0, 1, 16'd0, 32'd0, "R7 pointer held");
        // R10 hold without strobe
        access(1, 0, 0, 16'd0, 32'd0, "R10 hold");
        // R8 rewind with read strobe
        access(1, 1, 1, 16'd8, 32'd0, "R8 rewind+read");
        access(1, 0, 1, 16'd0, 32'd0, "R8 read bit0");
        // R9 write+read at offset 0
        access(1, 1, 1, 16'd0, 32'd0, "R9 rw same");
        access(1, 1, 1, 16'd0, 32'd1, "R9 rw same");
        access(1, 0, 1, 16'd0, 32'd0, "R9 next bit");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int unsigned k;
            logic [15:0] o;
            k = $urandom_range(0, 9);
            o = (k < 6) ? 16'd0 : (k < 8) ? 16'd8 : (k == 8) ? 16'd4 : 16'($urandom);
            access($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1,
                   $urandom_range(0, 1) == 1, o, $urandom, "random R2 R4");
        end

        // R1 reset again mid-run
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_cfg = '0; m_ptr = 0; m_rdata = '0;
        check("R1 re-reset");
        access(1, 0, 1, 16'd0, 32'd0, "R1 pointer zero");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule